// File: doc/BRIEF.md
# Serially Configured Output Switch Controller

This block drives twelve switch enables: four high-side channels and eight low-side channels. A host writes a 16-bit frame over a four-wire serial link in mode 0. The block decodes the frame into three registers. The state register holds the commanded level of each channel. The pin-enable register chooses, channel by channel, whether an external control pin takes part in that channel's output. The combine register chooses whether that pin is ANDed or ORed with the commanded level.

Each high-side channel has its own control pin. All eight low-side channels share one pin. A channel with pin control disabled follows its state bit only.

The serial interface is fire-and-forget and has no back-pressure. A frame takes effect when chip-select rises, provided exactly sixteen clocks were seen while chip-select was low. The system clock samples the serial pins. Each serial clock half-period must last at least three system clocks.

Top module: `out_switch_ctrl`

## Requirements
- R1: A frame is sent MSB first. `mosi` is sampled on each rising `sclk` edge while `cs_n` is low. Frame bit 15 is the watchdog flag, bits 14:12 are the register code, and bits 11:0 are data. Data bit k belongs to channel k: channels 3..0 are `hs_en[3:0]` and channels 11..4 are `ls_en[7:0]`.
- R2: Code 3'b000 writes the state register. A channel with pin control disabled then drives its enable equal to its state bit.
- R3: Code 3'b100 writes the pin-enable register. A 0 bit gives pin control to that channel. A 1 bit removes it, and pin changes then have no effect on that channel's output.
- R4: Code 3'b010 writes the combine register. For a pin-controlled channel, a 1 bit makes the output the AND of the state bit and the pin. A 0 bit makes it the OR.
- R5: High-side channel i (i = 0..3) combines with its own pin `hs_pin[i]`.
- R6: Every low-side channel combines with the single pin `ls_pin`.
- R7: A frame is discarded when chip-select rises after any number of `sclk` rising edges other than 16.
- R8: A complete frame with any other register code leaves all three registers unchanged.
- R9: After reset, every enable is 0, every channel has pin control disabled, and combine mode is OR.
- R10: `wd_flag` shows bit 15 of the last accepted frame, including frames with an unused code. It has no other effect. It is 0 after reset.
- R11: A change on a control pin reaches the outputs on the third rising `clk` edge after it: two synchronizer stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Serial chip-select, active low |
| mosi | input | 1 | Serial data in |
| hs_pin | input | 4 | High-side control pins, one per channel |
| ls_pin | input | 1 | Shared low-side control pin |
| hs_en | output | 4 | High-side enables, channels 3..0 |
| ls_en | output | 8 | Low-side enables, channels 11..4 |
| wd_flag | output | 1 | Watchdog bit of the last accepted frame |

## Verification
The bench sends frames with 15 and 17 clocks. A design that counts loosely or fails to saturate its counter would commit them and change the outputs.

It writes unused codes with all-ones data. A decoder that ignores one code bit would load a register and light outputs.

It mixes pin-controlled and state-only channels in one low-side group. Wrong pin routing or inverted enable polarity shows up there as half the byte moving the wrong way.

It measures the pin-to-output delay edge by edge, which exposes a missing or extra synchronizer stage. It also checks that `wd_flag` follows a frame with an unused code.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 3;
  localparam int DATA_W  = 12;
  localparam int HS_N    = 4;
  localparam int LS_N    = 8;

  typedef enum logic [CODE_W-1:0] {
    CODE_STATE = 3'b000,
    CODE_COMB  = 3'b010,
    CODE_PINEN = 3'b100
  } reg_code_e;

  typedef struct packed {
    logic              wd;
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/osc_spi_rx.sv
module osc_spi_rx
  import osc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk,
  input  logic   cs_n,
  input  logic   mosi,
  output logic   frm_valid,
  output frame_t frm
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_SAT = FRAME_W + 1;

  logic sclk_s, cs_s, mosi_s;
  logic sclk_d, cs_d;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;
  logic sclk_rise, cs_rise, cs_fall;

  osc_sync #(.W(3), .RST_VAL(3'b010)) u_pin_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, cs_n, mosi}),
    .q({sclk_s, cs_s, mosi_s})
  );

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = cs_s & ~cs_d;
  assign cs_fall   = ~cs_s & cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
      shreg     <= '0;
      bit_cnt   <= '0;
      frm_valid <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
      frm_valid <= cs_rise && (bit_cnt == CNT_W'(FRAME_W));
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (!cs_s && sclk_rise) begin
        shreg <= {shreg[FRAME_W-2:0], mosi_s};
        if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign frm = frame_t'(shreg);

  // R7: the counter saturates, so long frames never wrap back to 16
  a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(CNT_SAT));
  // R1: one commit per chip-select rise
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> !frm_valid);
endmodule

// File: rtl/osc_regfile.sv
module osc_regfile
  import osc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  frame_t            frm,
  output logic [DATA_W-1:0] state_q,
  output logic [DATA_W-1:0] pin_off_q,
  output logic [DATA_W-1:0] comb_and_q,
  output logic              wd_q
);
  logic code_known;

  always_comb begin
    unique case (frm.code)
      CODE_STATE, CODE_COMB, CODE_PINEN: code_known = 1'b1;
      default:                           code_known = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= '0;
      pin_off_q  <= '1;
      comb_and_q <= '0;
      wd_q       <= 1'b0;
    end else if (frm_valid) begin
      wd_q <= frm.wd;
      case (frm.code)
        CODE_STATE: state_q    <= frm.data;
        CODE_PINEN: pin_off_q  <= frm.data;
        CODE_COMB:  comb_and_q <= frm.data;
        default: ;
      endcase
    end
  end

  // R8: unused codes leave all registers untouched
  a_r8_unknown_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !code_known) |=> ($stable(state_q) && $stable(pin_off_q) && $stable(comb_and_q)));
  // R10: the flag moves only on an accepted frame
  a_r10_wd_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> $stable(wd_q));
  // R2: a state write lands its data
  a_r2_state_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm.code == CODE_STATE) |=> state_q == $past(frm.data));
endmodule

// File: rtl/osc_combine.sv
module osc_combine
  import osc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] state_q,
  input  logic [DATA_W-1:0] pin_off_q,
  input  logic [DATA_W-1:0] comb_and_q,
  input  logic [HS_N-1:0]   hs_pin_s,
  input  logic              ls_pin_s,
  output logic [HS_N-1:0]   hs_en,
  output logic [LS_N-1:0]   ls_en
);
  logic [DATA_W-1:0] ch_pin, ch_next, ch_q;

  for (genvar k = 0; k < DATA_W; k++) begin : g_ch
    if (k < HS_N) begin : g_hs
      assign ch_pin[k] = hs_pin_s[k];
    end else begin : g_ls
      assign ch_pin[k] = ls_pin_s;
    end
    always_comb begin
      if (pin_off_q[k])       ch_next[k] = state_q[k];
      else if (comb_and_q[k]) ch_next[k] = state_q[k] & ch_pin[k];
      else                    ch_next[k] = state_q[k] | ch_pin[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_q <= '0;
    else        ch_q <= ch_next;
  end

  assign hs_en = ch_q[HS_N-1:0];
  assign ls_en = ch_q[DATA_W-1:HS_N];

  // R4: AND mode with a low pin forces a pin-controlled channel off
  a_r4_and_low_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_off_q[0] && comb_and_q[0] && !hs_pin_s[0]) |=> !hs_en[0]);
  // R6: OR mode with the shared pin high drives a low-side channel on
  a_r6_or_shared_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_off_q[HS_N] && !comb_and_q[HS_N] && ls_pin_s) |=> ls_en[0]);
endmodule

// File: rtl/out_switch_ctrl.sv
module out_switch_ctrl
  import osc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [3:0] hs_pin,
  input  logic       ls_pin,
  output logic [3:0] hs_en,
  output logic [7:0] ls_en,
  output logic       wd_flag
);
  logic              frm_valid;
  frame_t            frm;
  logic [DATA_W-1:0] state_q, pin_off_q, comb_and_q;
  logic [HS_N-1:0]   hs_pin_s;
  logic              ls_pin_s;

  osc_spi_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .frm_valid(frm_valid), .frm(frm)
  );

  osc_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm(frm),
    .state_q(state_q), .pin_off_q(pin_off_q), .comb_and_q(comb_and_q),
    .wd_q(wd_flag)
  );

  osc_sync #(.W(HS_N + 1), .RST_VAL('0)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ls_pin, hs_pin}),
    .q({ls_pin_s, hs_pin_s})
  );

  osc_combine u_comb (
    .clk(clk), .rst_n(rst_n),
    .state_q(state_q), .pin_off_q(pin_off_q), .comb_and_q(comb_and_q),
    .hs_pin_s(hs_pin_s), .ls_pin_s(ls_pin_s),
    .hs_en(hs_en), .ls_en(ls_en)
  );

  // R3: a channel without pin control ignores its pin
  a_r3_off_channel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_off_q[0] && $stable(pin_off_q) && $stable(state_q)) |=> $stable(hs_en[0]));
endmodule

// File: tb/out_switch_ctrl_bench.sv
module out_switch_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [3:0] hs_pin = '0;
  logic ls_pin = 1'b0;
  logic [3:0] hs_en;
  logic [7:0] ls_en;
  logic wd_flag;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  out_switch_ctrl u_out_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .hs_pin(hs_pin), .ls_pin(ls_pin), .hs_en(hs_en), .ls_en(ls_en),
    .wd_flag(wd_flag)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_send(input logic [31:0] w, input int nbits);
    cs_n = 1'b0;
    wait_clk(4);
    for (int b = nbits - 1; b >= 0; b--) begin
      mosi = w[b];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(12);
  endtask

  function automatic logic [31:0] fr(input logic wd, input logic [2:0] code, input logic [11:0] d);
    return {16'h0, wd, code, d};
  endfunction

  task automatic chk(input string req, input logic [3:0] ehs, input logic [7:0] els);
    n_chk++;
    if (hs_en !== ehs || ls_en !== els) begin
      n_err++;
      $display("FAIL %s: hs_en=%h ls_en=%h expected hs_en=%h ls_en=%h", req, hs_en, ls_en, ehs, els);
    end
  endtask

  task automatic chk_wd(input string req, input logic e);
    n_chk++;
    if (wd_flag !== e) begin
      n_err++;
      $display("FAIL %s: wd_flag=%b expected %b", req, wd_flag, e);
    end
  endtask

  task automatic t_reset;
    chk("R9 reset outputs", 4'h0, 8'h00);
    chk_wd("R10 reset flag", 1'b0);
    hs_pin = 4'hF; ls_pin = 1'b1;
    wait_clk(6);
    chk("R9 pins ignored after reset", 4'h0, 8'h00);
    hs_pin = 4'h0; ls_pin = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_state_write;
    spi_send(fr(1'b0, 3'b000, 12'hA5C), 16);
    chk("R1 R2 state write", 4'hC, 8'hA5);
    hs_pin = 4'hF; ls_pin = 1'b1;
    wait_clk(6);
    chk("R3 disabled channels ignore pins", 4'hC, 8'hA5);
    hs_pin = 4'h0; ls_pin = 1'b0;
    wait_clk(6);
  endtask

  task automatic t_or_mode;
    spi_send(fr(1'b0, 3'b000, 12'h000), 16);
    spi_send(fr(1'b0, 3'b100, 12'h000), 16);
    hs_pin = 4'b0101; ls_pin = 1'b0;
    wait_clk(6);
    chk("R4 R5 OR with own pins", 4'h5, 8'h00);
    ls_pin = 1'b1;
    wait_clk(6);
    chk("R6 shared pin drives all low side", 4'h5, 8'hFF);
  endtask

  task automatic t_latency;
    hs_pin = 4'b0111;
    @(posedge clk); @(posedge clk); #1;
    chk("R11 no change after two edges", 4'h5, 8'hFF);
    @(posedge clk); #1;
    chk("R11 change on third edge", 4'h7, 8'hFF);
    wait_clk(2);
  endtask

  task automatic t_and_mode;
    spi_send(fr(1'b0, 3'b010, 12'hFFF), 16);
    spi_send(fr(1'b0, 3'b000, 12'hF0F), 16);
    hs_pin = 4'b1001; ls_pin = 1'b1;
    wait_clk(6);
    chk("R4 AND mode pins high", 4'h9, 8'hF0);
    ls_pin = 1'b0;
    wait_clk(6);
    chk("R4 R6 AND mode shared pin low", 4'h9, 8'h00);
  endtask

  task automatic t_mixed;
    spi_send(fr(1'b0, 3'b010, 12'h000), 16);
    spi_send(fr(1'b0, 3'b000, 12'h000), 16);
    spi_send(fr(1'b0, 3'b100, 12'h0FF), 16);
    hs_pin = 4'hF; ls_pin = 1'b1;
    wait_clk(6);
    chk("R3 R6 mixed pin control", 4'h0, 8'hF0);
  endtask

  task automatic t_bad_length;
    spi_send(fr(1'b1, 3'b000, 12'hFFF) >> 1, 15);
    chk("R7 15-bit frame dropped", 4'h0, 8'hF0);
    chk_wd("R7 15-bit frame leaves flag", 1'b0);
    spi_send(fr(1'b1, 3'b000, 12'hFFF) << 1, 17);
    chk("R7 17-bit frame dropped", 4'h0, 8'hF0);
  endtask

  task automatic t_bad_code;
    spi_send(fr(1'b0, 3'b001, 12'hFFF), 16);
    chk("R8 code 001 ignored", 4'h0, 8'hF0);
    spi_send(fr(1'b0, 3'b111, 12'hFFF), 16);
    chk("R8 code 111 ignored", 4'h0, 8'hF0);
    spi_send(fr(1'b0, 3'b110, 12'h000), 16);
    chk("R8 code 110 ignored", 4'h0, 8'hF0);
  endtask

  task automatic t_wd;
    spi_send(fr(1'b1, 3'b011, 12'hFFF), 16);
    chk_wd("R10 flag from unused code", 1'b1);
    chk("R10 flag has no other effect", 4'h0, 8'hF0);
    spi_send(fr(1'b0, 3'b000, 12'h001), 16);
    chk_wd("R10 flag cleared", 1'b0);
    chk("R2 state write after flag", 4'h1, 8'hF0);
  endtask

  initial begin
    #800000;
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_state_write();
    t_or_mode();
    t_latency();
    t_and_mode();
    t_mixed();
    t_bad_length();
    t_bad_code();
    t_wd();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule